// File: doc/BRIEF.md
# I2C SCL Baud-Rate Generator

This block sets the SCL timing for an I2C master that runs from a single system clock. Each SCL period has a low phase, in which the block pulls SCL down, and a high phase, in which it releases SCL. The lengths of both phases are whole multiples of a 16-bit divisor. The speed mode sets how many divisor units go into the low phase. Two single-cycle pulses come out of the block. One marks the point where the data path may change SDA, at the start of each low phase. The other marks the point where SDA should be sampled, which is the first cycle in which SCL is actually read back high.

A target can stretch the clock by holding SCL low while the block has released it. The block reads SCL back and freezes its high-phase count until the line rises. After a stretched high phase it keeps SCL low for a programmable number of system cycles before the next low phase, and therefore before the next change pulse. This gives the data path a guaranteed setup window. Software computes the divisor as f_clk / (f_scl × 2) for standard mode or f_clk / (f_scl × 3) for fast mode.

Top module: `scl_baud_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle has scl_drive_low, chg_tick and smp_tick all at 0.
- R2: With speed_mode = 0 and divisor D (baud_word[15:0]), each period drives SCL low for D cycles and then releases it for D cycles, provided SCL is not stretched.
- R3: With speed_mode = 1, each period drives SCL low for 2×D cycles and releases it for D cycles.
- R4: speed_mode values 2 and 3 give exactly the standard-mode timing of R2.
- R5: baud_word[31:16] has no effect on any output.
- R6: When en is low, or the divisor is 0 at a period start, SCL is released and no ticks occur from the next cycle on. Generation starts one cycle after en is sampled high with a nonzero divisor.
- R7: chg_tick is high only in the first cycle of each low phase. smp_tick is high only in the first high-phase cycle in which scl_in reads 1. The two never coincide.
- R8: While SCL is released but scl_in reads 0, the high-phase count stops. The high phase then lasts D counted cycles in which scl_in is 1.
- R9: After a high phase in which scl_in read 0 at least once, SCL is driven low for setup_cycles cycles with no tick before the next low phase. A setup_cycles value of 0 adds no cycles. A high phase with no stretch adds no setup cycles.
- R10: Divisor and mode are sampled only at a period start (leaving idle, or at the end of a high phase or setup wait), so a change made in the middle of a period takes effect at the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Generator enable |
| baud_word | input | 32 | Divisor in [15:0]; [31:16] unused |
| speed_mode | input | 2 | 1 = fast, any other value = standard |
| setup_cycles | input | 16 | Setup wait after a stretched high phase, in system cycles |
| scl_in | input | 1 | SCL level read back from the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| chg_tick | output | 1 | Pulse where SDA may change |
| smp_tick | output | 1 | Pulse where SDA should be sampled |

## Verification
The hardest situation to reach is a stretch that begins at a chosen offset inside a released phase. Two variants matter most: one that starts before the first counted high cycle, so the sample pulse must wait, and one that starts late in the phase, so the setup wait must still follow. The stimulus waits for the generator to release SCL, counts a chosen number of cycles, and then holds the line low for a chosen length. It repeats this with a nonzero setup count, with a zero setup count, and in fast mode. A behavioural model in the bench tracks phase, count and stretch state every cycle, so divisor changes made in the middle of a period are checked against the period-boundary rule.

// File: rtl/scl_baud_pkg.sv
// Shared types for the SCL baud generator.
// Assumes: speed mode field is 2 bits; only code 1 selects fast timing.
package scl_baud_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_HIGH  = 2'd2,
        PH_SETUP = 2'd3
    } scl_phase_t;

    localparam logic [1:0] MODE_FAST = 2'd1;

    // Decode the speed field: anything but the fast code runs standard.
    function automatic logic mode_is_fast(input logic [1:0] mode);
        return (mode == MODE_FAST);
    endfunction
endpackage

// File: rtl/scl_len_calc.sv
// Phase length calculator.
// Turns a divisor and a speed mode into low and high phase lengths in
// system cycles. Purely combinational; assumes the caller samples the
// results only at a period start.
module scl_len_calc #(
    parameter int DIV_W     = 16,
    parameter int STD_LOW   = 1,
    parameter int FAST_LOW  = 2,
    parameter int HIGH_UNIT = 1,
    parameter int LEN_W     = DIV_W + 2
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       mode,
    output logic [LEN_W-1:0] lo_len,
    output logic [LEN_W-1:0] hi_len,
    output logic             div_zero
);
    import scl_baud_pkg::*;

    logic [LEN_W-1:0] div_ext;

    // Widen the divisor so products cannot overflow.
    always_comb div_ext = LEN_W'(divisor);

    // Pick the low-phase multiplier from the mode.
    always_comb begin
        if (mode_is_fast(mode)) lo_len = div_ext * LEN_W'(FAST_LOW);
        else                    lo_len = div_ext * LEN_W'(STD_LOW);
    end

    // High phase is the same unit count in every supported mode.
    always_comb hi_len = div_ext * LEN_W'(HIGH_UNIT);

    // Flag a zero divisor, which parks the generator.
    always_comb div_zero = (divisor == '0);
endmodule

// File: rtl/scl_phase_fsm.sv
// SCL phase sequencer.
// Steps through idle, low, high and the post-stretch setup wait. It
// latches the lengths at each period start, freezes the high count while
// SCL reads low, and remembers that a stretch occurred. Assumes lo_len
// and hi_len are nonzero whenever div_zero is 0.
module scl_phase_fsm #(
    parameter int LEN_W   = 18,
    parameter int SETUP_W = 16,
    parameter int CNT_W   = (LEN_W > SETUP_W) ? LEN_W : SETUP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [LEN_W-1:0]         lo_len,
    input  logic [LEN_W-1:0]         hi_len,
    input  logic                     div_zero,
    input  logic [SETUP_W-1:0]       setup_cycles,
    input  logic                     scl_in,
    output scl_baud_pkg::scl_phase_t phase,
    output logic [CNT_W-1:0]         cnt,
    output logic                     stretched
);
    import scl_baud_pkg::*;

    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] setup_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             lo_done;
    logic             hi_done;
    logic             setup_done;
    logic             want_setup;

    // Next count value and phase-end detection.
    always_comb begin
        cnt_inc    = cnt + 1'b1;
        lo_done    = (cnt_inc == lo_q);
        hi_done    = (cnt_inc == hi_q);
        setup_done = (cnt_inc == setup_q);
        want_setup = stretched && (setup_cycles != '0);
    end

    // Phase, counter and latched-length registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            stretched <= 1'b0;
            if (!rst_n) begin
                lo_q    <= '0;
                hi_q    <= '0;
                setup_q <= '0;
            end
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!div_zero) begin
                        phase     <= PH_LOW;
                        cnt       <= '0;
                        lo_q      <= CNT_W'(lo_len);
                        hi_q      <= CNT_W'(hi_len);
                        stretched <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (lo_done) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in) begin
                        stretched <= 1'b1;
                    end else if (hi_done) begin
                        cnt <= '0;
                        if (want_setup) begin
                            phase   <= PH_SETUP;
                            setup_q <= CNT_W'(setup_cycles);
                        end else if (div_zero) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase     <= PH_LOW;
                            lo_q      <= CNT_W'(lo_len);
                            hi_q      <= CNT_W'(hi_len);
                            stretched <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_SETUP: begin
                    if (setup_done) begin
                        cnt <= '0;
                        if (div_zero) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase     <= PH_LOW;
                            lo_q      <= CNT_W'(lo_len);
                            hi_q      <= CNT_W'(hi_len);
                            stretched <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scl_tick_out.sv
// Output decoder.
// Derives the SCL drive and the two timing pulses from the phase and
// count. Assumes the sequencer holds the count at 0 during a stretch
// that begins in the first high cycle.
module scl_tick_out #(
    parameter int CNT_W = 18
) (
    input  scl_baud_pkg::scl_phase_t phase,
    input  logic [CNT_W-1:0]         cnt,
    input  logic                     scl_in,
    output logic                     scl_drive_low,
    output logic                     chg_tick,
    output logic                     smp_tick
);
    import scl_baud_pkg::*;

    logic first_cycle;

    // First cycle of the current phase.
    always_comb first_cycle = (cnt == '0);

    // Hold SCL low during the low phase and the setup wait.
    always_comb scl_drive_low = (phase == PH_LOW) || (phase == PH_SETUP);

    // Data-change pulse opens each low phase.
    always_comb chg_tick = (phase == PH_LOW) && first_cycle;

    // Sample pulse on the first high cycle the line really reads high.
    always_comb smp_tick = (phase == PH_HIGH) && first_cycle && scl_in;
endmodule

// File: rtl/scl_baud_gen.sv
// I2C SCL baud-rate generator top.
// Extracts the divisor from the lower half of the baud word, computes
// the phase lengths and runs the phase sequencer. Assumes scl_in is
// already synchronised to clk.
module scl_baud_gen #(
    parameter int BAUD_W   = 32,
    parameter int DIV_W    = 16,
    parameter int SETUP_W  = 16,
    parameter int STD_LOW  = 1,
    parameter int FAST_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BAUD_W-1:0] baud_word,
    input  logic [1:0]        speed_mode,
    input  logic [SETUP_W-1:0] setup_cycles,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              chg_tick,
    output logic              smp_tick
);
    import scl_baud_pkg::*;

    localparam int LEN_W = DIV_W + $clog2(FAST_LOW + 1);
    localparam int CNT_W = (LEN_W > SETUP_W) ? LEN_W : SETUP_W;

    logic [DIV_W-1:0] divisor;
    logic [LEN_W-1:0] lo_len;
    logic [LEN_W-1:0] hi_len;
    logic             div_zero;
    scl_phase_t       phase;
    logic [CNT_W-1:0] cnt;
    logic             stretched;

    // Only the standard/fast counter field is used.
    always_comb divisor = baud_word[DIV_W-1:0];

    scl_len_calc #(
        .DIV_W(DIV_W), .STD_LOW(STD_LOW), .FAST_LOW(FAST_LOW),
        .HIGH_UNIT(1), .LEN_W(LEN_W)
    ) u_len (
        .divisor(divisor), .mode(speed_mode),
        .lo_len(lo_len), .hi_len(hi_len), .div_zero(div_zero)
    );

    scl_phase_fsm #(
        .LEN_W(LEN_W), .SETUP_W(SETUP_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en),
        .lo_len(lo_len), .hi_len(hi_len), .div_zero(div_zero),
        .setup_cycles(setup_cycles), .scl_in(scl_in),
        .phase(phase), .cnt(cnt), .stretched(stretched)
    );

    scl_tick_out #(.CNT_W(CNT_W)) u_out (
        .phase(phase), .cnt(cnt), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .chg_tick(chg_tick),
        .smp_tick(smp_tick)
    );
endmodule

// File: rtl/scl_baud_gen_chk.sv
// Property checker for the SCL baud generator, bound into the top.
// Assumes a synchronous active-low reset.
module scl_baud_gen_chk #(
    parameter int CNT_W = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic                     scl_in,
    input logic                     scl_drive_low,
    input logic                     chg_tick,
    input logic                     smp_tick,
    input scl_baud_pkg::scl_phase_t phase,
    input logic [CNT_W-1:0]         cnt
);
    import scl_baud_pkg::*;

    a_r7_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_tick && smp_tick));

    a_r7_chg_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        chg_tick |-> scl_drive_low);

    a_r7_smp_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> (!scl_drive_low && scl_in));

    a_r6_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drive_low && !chg_tick && !smp_tick));

    a_r8_count_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == PH_HIGH && !scl_in) |=> $stable(cnt));

    a_r9_setup_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |-> (!chg_tick && !smp_tick));
endmodule

bind scl_baud_gen scl_baud_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .chg_tick(chg_tick),
    .smp_tick(smp_tick), .phase(phase), .cnt(cnt)
);

// File: tb/tb_scl_baud_gen.sv
module tb_scl_baud_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] baud_word = '0;
    logic [1:0]  speed_mode = '0;
    logic [15:0] setup_cycles = '0;
    logic        stretch = 1'b0;
    logic        scl_line;
    logic        scl_drive_low, chg_tick, smp_tick;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state: 0 idle, 1 low, 2 high, 3 setup.
    int m_ph = 0, m_cnt = 0, m_lo = 0, m_hi = 0, m_set = 0;
    bit m_str = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = ~scl_drive_low & ~stretch;

    scl_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .baud_word(baud_word),
        .speed_mode(speed_mode), .setup_cycles(setup_cycles),
        .scl_in(scl_line), .scl_drive_low(scl_drive_low),
        .chg_tick(chg_tick), .smp_tick(smp_tick)
    );

    function automatic bit m_line();
        return !(m_ph == 1 || m_ph == 3) && !stretch;
    endfunction

    task automatic m_start();
        int d;
        d = int'(baud_word[15:0]);
        if (d == 0) begin
            m_ph = 0;
        end else begin
            m_ph  = 1;
            m_lo  = (speed_mode == 2'd1) ? 2 * d : d;
            m_hi  = d;
            m_str = 1'b0;
        end
        m_cnt = 0;
    endtask

    // Behavioural model update from inputs held since the last negedge.
    always @(posedge clk) begin
        bit ln;
        ln = m_line();
        if (!rst_n || !en) begin
            m_ph = 0; m_cnt = 0; m_str = 1'b0;
        end else if (m_ph == 0) begin
            m_start();
        end else if (m_ph == 1) begin
            if (m_cnt + 1 == m_lo) begin m_ph = 2; m_cnt = 0; end
            else m_cnt++;
        end else if (m_ph == 2) begin
            if (!ln) m_str = 1'b1;
            else if (m_cnt + 1 == m_hi) begin
                if (m_str && setup_cycles != 0) begin
                    m_ph = 3; m_cnt = 0; m_set = int'(setup_cycles);
                end else m_start();
            end else m_cnt++;
        end else begin
            if (m_cnt + 1 == m_set) m_start();
            else m_cnt++;
        end
    end

    // Compare every cycle, a quarter period after the edge.
    always @(posedge clk) begin
        bit e_drv, e_chg, e_smp;
        #(CLK_PERIOD/4);
        if (!done) begin
            e_drv = (m_ph == 1 || m_ph == 3);
            e_chg = (m_ph == 1 && m_cnt == 0);
            e_smp = (m_ph == 2 && m_cnt == 0 && m_line());
            n_tests++;
            if ({scl_drive_low, chg_tick, smp_tick} !== {e_drv, e_chg, e_smp}) begin
                n_fail++;
                $display("FAIL %s drv/chg/smp act=%b%b%b exp=%b%b%b t=%0t",
                         cur_req, scl_drive_low, chg_tick, smp_tick,
                         e_drv, e_chg, e_smp, $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release();
        while (!scl_drive_low) @(negedge clk);
        while (scl_drive_low) @(negedge clk);
    endtask

    task automatic stretch_at(input int delay, input int len);
        wait_release();
        cycles(delay);
        stretch = 1'b1;
        cycles(len);
        stretch = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset holds everything quiet even with enable set.
        cur_req = "R1";
        en = 1'b1; baud_word = 32'd3;
        cycles(4);
        n_tests++;
        if (scl_drive_low || chg_tick || smp_tick) begin
            n_fail++;
            $display("FAIL R1 outputs act=%b%b%b exp=000",
                     scl_drive_low, chg_tick, smp_tick);
        end
        rst_n = 1'b1;
        // R2: standard timing, two divisors.
        cur_req = "R2";
        cycles(40);
        baud_word = 32'd1; cycles(20);
        // R3: fast timing.
        cur_req = "R3";
        speed_mode = 2'd1; baud_word = 32'd4; cycles(60);
        // R4: unsupported mode codes fall back to standard.
        cur_req = "R4";
        speed_mode = 2'd2; cycles(40);
        speed_mode = 2'd3; cycles(40);
        // R5: upper half of the baud word is ignored.
        cur_req = "R5";
        speed_mode = 2'd0; baud_word = 32'hFFFF_0005; cycles(50);
        baud_word = 32'h1234_0005; cycles(30);
        // R10: change divisor and mode inside a low phase.
        cur_req = "R10";
        wait_release();
        while (!scl_drive_low) @(negedge clk);
        cycles(1);
        baud_word = 32'd2; speed_mode = 2'd1;
        cycles(40);
        // R8: stretch from the first released cycle, then late.
        cur_req = "R8";
        speed_mode = 2'd0; baud_word = 32'd4; setup_cycles = 16'd0;
        stretch_at(0, 5); cycles(20);
        stretch_at(3, 2); cycles(20);
        // R9: setup wait after a stretch, zero and nonzero.
        cur_req = "R9";
        setup_cycles = 16'd6;
        stretch_at(1, 4); cycles(30);
        speed_mode = 2'd1; baud_word = 32'd3; setup_cycles = 16'd2;
        stretch_at(2, 3); cycles(30);
        setup_cycles = 16'd0;
        stretch_at(0, 2); cycles(30);
        // R7: pulse placement with divisor 1 under a stretch.
        cur_req = "R7";
        speed_mode = 2'd0; baud_word = 32'd1; setup_cycles = 16'd3;
        stretch_at(0, 3); cycles(20);
        // R6: zero divisor parks, enable drop quiets.
        cur_req = "R6";
        baud_word = 32'hABCD_0000; cycles(30);
        baud_word = 32'd3; cycles(15);
        en = 1'b0; cycles(10);
        en = 1'b1; cycles(20);
        finish_run();
    end
endmodule